// File: doc/BRIEF.md
# Tristate Phase Comparator with Lock Indication

This block forms the heart of a frequency synthesiser loop. It runs on the reference clock and divides it by a programmable 16-bit ratio to produce a comparison tick. It watches the divided-down oscillator signal for rising edges and compares their timing with that tick. The result drives a three-state charge-pump control, encoded as two enables. One enable steers the pump up and the other steers it down. When both are low the pump output is high-impedance.

The correction pulse lasts as many reference cycles as the phase error between the two edges. A polarity input decides which direction counts as "up", so the block suits oscillators whose tuning slope is either positive or negative. When the two edges coincide, no pulse is produced. An active-low lock indicator goes low for exactly the length of each correction pulse, so a slow monitor can integrate it to judge how close the loop is to lock. When the enable input is low, the comparator is held idle.

Top module: `pfd_phase_cmp`

## Requirements
- R1: While enabled, the reference tick occurs in the first enabled cycle and then once every R reference cycles, where R is the `r_ratio` value; a ratio of 0 or 1 gives a tick in every cycle.
- R2: An oscillator edge is a cycle in which `fvn_in` is high and it was low in the previous cycle; only edges seen while enabled take part.
- R3: When one edge precedes the other by d reference cycles (d below R), exactly one enable is high for exactly d consecutive cycles, starting the cycle after the earlier edge.
- R4: With `polarity` = 1, a reference tick leading the oscillator edge raises `up_en`, and an oscillator edge leading the tick raises `dn_en`.
- R5: With `polarity` = 0, the mapping of R4 is swapped: tick leading raises `dn_en`, and oscillator edge leading raises `up_en`.
- R6: When the tick and the oscillator edge fall in the same cycle, both enables stay low, which is the high-impedance state.
- R7: `up_en` and `dn_en` are never high together.
- R8: If ticks keep arriving without any oscillator edge, the leading-side enable stays high continuously, so a frequency error gives a steady one-sided drive.
- R9: `ld_n` is low exactly in the cycles in which `up_en` or `dn_en` is high, and high otherwise.
- R10: While `enable` is low, both enables are low from the next clock edge onward, and oscillator edges have no effect.
- R11: During reset, `up_en` and `dn_en` are low and `ld_n` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Reference clock; every register runs on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Runs the divider and the comparator; low holds them idle |
| r_ratio | input | 16 | Reference division ratio R |
| polarity | input | 1 | 1: reference leading drives up; 0: inverted |
| fvn_in | input | 1 | Divided oscillator signal, synchronous to clk_ref |
| up_en | output | 1 | Charge-pump source enable |
| dn_en | output | 1 | Charge-pump sink enable |
| ld_n | output | 1 | Active-low lock indicator, low while a correction pulse is active |

## Verification
The assertions assume that `fvn_in` is already synchronous to the reference clock. They also assume that `r_ratio` holds steady for the cycle after a tick, so that the reload it takes can be compared with the ratio. The stimulus changes every input only at the falling clock edge. It changes the ratio and the polarity only while `enable` is low. It places oscillator edges within one reference period of a tick, so each measured pulse comes from a single, known edge pair.

// File: rtl/pfd_pkg.sv
package pfd_pkg;

    // Charge-pump drive request as seen at the block's edge
    typedef enum logic [1:0] {
        DRV_HIZ  = 2'b00,
        DRV_UP   = 2'b01,
        DRV_DOWN = 2'b10
    } drive_t;

    // Comparator core state: which side leads, last oscillator sample
    typedef struct packed {
        logic lead;
        logic lag;
        logic fvn_prev;
    } pfd_state_t;

endpackage

// File: rtl/pfd_ref_div.sv
module pfd_ref_div #(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic [W-1:0] ratio,
    output logic         fc_tick
);
    localparam logic [W-1:0] ONE = W'(1);

    typedef struct packed {
        logic [W-1:0] cnt;
    } div_state_t;

    div_state_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        fc_tick = en && (st_q.cnt == '0);
        if (!en) begin
            st_d.cnt = '0;
        end else if (fc_tick) begin
            st_d.cnt = (ratio > ONE) ? (ratio - ONE) : '0;
        end else begin
            st_d.cnt = st_q.cnt - ONE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R1
    reload_ratio_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && fc_tick && (ratio > ONE)) |=> (st_q.cnt == $past(ratio) - ONE));

endmodule

// File: rtl/pfd_core.sv
module pfd_core
    import pfd_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic fc_tick,
    input  logic fvn,
    output logic lead,
    output logic lag
);
    pfd_state_t st_d, st_q;
    logic fvn_rise;
    logic ref_set;
    logic var_set;

    always_comb begin
        st_d          = st_q;
        fvn_rise      = en && fvn && !st_q.fvn_prev;
        ref_set       = st_q.lead || fc_tick;
        var_set       = st_q.lag  || fvn_rise;
        st_d.fvn_prev = fvn;
        if (!en || (ref_set && var_set)) begin
            st_d.lead = 1'b0;
            st_d.lag  = 1'b0;
        end else begin
            st_d.lead = ref_set;
            st_d.lag  = var_set;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign lead = st_q.lead;
    assign lag  = st_q.lag;

    // R7
    excl_side_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(st_q.lead && st_q.lag));

    // R6
    coincide_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && fc_tick && fvn_rise && !st_q.lead && !st_q.lag) |=> (!lead && !lag));

    // R10
    idle_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (!lead && !lag));

endmodule

// File: rtl/pfd_out_map.sv
module pfd_out_map
    import pfd_pkg::*;
(
    input  logic lead,
    input  logic lag,
    input  logic pol,
    output logic up_en,
    output logic dn_en,
    output logic ld_n
);
    drive_t drv;

    always_comb begin
        drv = DRV_HIZ;
        if (lead && !lag)      drv = pol ? DRV_UP : DRV_DOWN;
        else if (lag && !lead) drv = pol ? DRV_DOWN : DRV_UP;
        up_en = (drv == DRV_UP);
        dn_en = (drv == DRV_DOWN);
        ld_n  = (drv == DRV_HIZ);
    end

endmodule

// File: rtl/pfd_phase_cmp.sv
module pfd_phase_cmp #(
    parameter int unsigned R_WIDTH = 16
) (
    input  logic               clk_ref,
    input  logic               rst_n,
    input  logic               enable,
    input  logic [R_WIDTH-1:0] r_ratio,
    input  logic               polarity,
    input  logic               fvn_in,
    output logic               up_en,
    output logic               dn_en,
    output logic               ld_n
);
    logic fc_tick;
    logic lead;
    logic lag;

    pfd_ref_div #(.W(R_WIDTH)) u_div (
        .clk     (clk_ref),
        .rst_n   (rst_n),
        .en      (enable),
        .ratio   (r_ratio),
        .fc_tick (fc_tick)
    );

    pfd_core u_core (
        .clk     (clk_ref),
        .rst_n   (rst_n),
        .en      (enable),
        .fc_tick (fc_tick),
        .fvn     (fvn_in),
        .lead    (lead),
        .lag     (lag)
    );

    pfd_out_map u_map (
        .lead  (lead),
        .lag   (lag),
        .pol   (polarity),
        .up_en (up_en),
        .dn_en (dn_en),
        .ld_n  (ld_n)
    );

    // R7
    pump_onehot_chk: assert property (@(posedge clk_ref) disable iff (!rst_n)
        $onehot0({up_en, dn_en}));

    // R9
    ld_tracks_pump_chk: assert property (@(posedge clk_ref) disable iff (!rst_n)
        (up_en || dn_en) |-> !ld_n);

endmodule

// File: tb/pfd_phase_cmp_test.sv
module pfd_phase_cmp_test;
    localparam int CLK_P = 10;
    localparam int NV = 8;
    localparam int V_R [NV] = '{8, 8, 8, 8, 8, 16, 3, 300};
    localparam int V_P [NV] = '{1, 1, 0, 0, 1, 1, 0, 1};
    localparam int V_D [NV] = '{3, -2, 3, -5, 0, 7, -1, 150};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable = 1'b0;
    logic [15:0] r_ratio = 16'd8;
    logic        polarity = 1'b1;
    logic        fvn_in = 1'b0;
    logic        up_en, dn_en, ld_n;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    pfd_phase_cmp uut (
        .clk_ref(clk), .rst_n(rst_n), .enable(enable), .r_ratio(r_ratio),
        .polarity(polarity), .fvn_in(fvn_in),
        .up_en(up_en), .dn_en(dn_en), .ld_n(ld_n)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic run_vec(input int r, input int p, input int d);
        int up_c = 0, dn_c = 0, ld_c = 0, both_c = 0, start_c = 0;
        int exp_lead, exp_lag;
        @(negedge clk);
        enable = 1'b0; fvn_in = 1'b0; r_ratio = 16'(r); polarity = p[0];
        repeat (3) @(negedge clk);
        enable = 1'b1; fvn_in = 1'b1;           // index 0: tick and edge together
        @(negedge clk);                          // after E0
        start_c = int'(up_en) + int'(dn_en);
        fvn_in = (1 == r + d);
        for (int k = 1; k <= 2*r - 1; k++) begin
            @(negedge clk);
            up_c   += int'(up_en);
            dn_c   += int'(dn_en);
            ld_c   += int'(!ld_n);
            both_c += int'(up_en && dn_en);
            fvn_in = (k + 1 == r + d);
        end
        exp_lead = (d > 0) ? d : 0;
        exp_lag  = (d < 0) ? -d : 0;
        chk("R6 start coincident quiet", start_c, 0);
        if (p != 0) begin
            chk("R1 R3 R4 up width", up_c, exp_lead);
            chk("R1 R3 R4 down width", dn_c, exp_lag);
        end else begin
            chk("R1 R3 R5 up width", up_c, exp_lag);
            chk("R1 R3 R5 down width", dn_c, exp_lead);
        end
        chk("R9 ld_n low width", ld_c, exp_lead + exp_lag);
        chk("R7 both high count", both_c, 0);
        @(negedge clk);
        enable = 1'b0; fvn_in = 1'b0;
    endtask

    initial begin
        #(CLK_P * 150000);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int bad;
        // R11 reset state
        repeat (3) @(negedge clk);
        chk("R11 up_en in reset", int'(up_en), 0);
        chk("R11 dn_en in reset", int'(dn_en), 0);
        chk("R11 ld_n in reset", int'(ld_n), 1);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // table walk: R3 R4 R5 R6 R7 R9 and R1 period
        for (int i = 0; i < NV; i++) run_vec(V_R[i], V_P[i], V_D[i]);

        // R8: no oscillator edges, steady one-sided drive
        @(negedge clk);
        r_ratio = 16'd5; polarity = 1'b1; fvn_in = 1'b0; enable = 1'b1;
        bad = 0;
        for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            bad += int'(!(up_en && !dn_en && !ld_n));
        end
        chk("R8 steady up drive misses", bad, 0);

        // R10: disable clears, edges ignored
        enable = 1'b0; fvn_in = 1'b1;
        @(negedge clk);
        chk("R10 up cleared on disable", int'(up_en), 0);
        chk("R10 ld_n high on disable", int'(ld_n), 1);
        bad = 0;
        for (int k = 0; k < 8; k++) begin
            fvn_in = ~fvn_in;
            @(negedge clk);
            bad += int'(up_en) + int'(dn_en) + int'(!ld_n);
        end
        chk("R10 R2 edges ignored while disabled", bad, 0);

        // R1 R2: ratio 0 and 1 tick every cycle; edge every second cycle
        for (int rr = 0; rr < 2; rr++) begin
            @(negedge clk);
            enable = 1'b0; fvn_in = 1'b0; r_ratio = 16'(rr); polarity = 1'b0;
            repeat (2) @(negedge clk);
            enable = 1'b1; fvn_in = 1'b1;
            bad = 0;
            @(negedge clk);
            fvn_in = 1'b0;
            for (int k = 1; k <= 6; k++) begin
                @(negedge clk);
                bad += int'(dn_en != (k % 2 == 1)) + int'(up_en);
                fvn_in = ((k + 1) % 2 == 0);
            end
            chk("R1 R2 R5 small ratio pattern", bad, 0);
        end
        @(negedge clk);
        enable = 1'b0;

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule